// File: doc/BRIEF.md
# Block-Parallel Transpose FIR Filter

This block is a finite impulse response filter that takes L new samples on every clock where input is valid and returns L filtered samples for each such block. The N coefficient taps (N = M·L) are fixed at build time and are split into M groups of L taps each. Every group multiplies the same window of samples. That window holds the current block plus the newest L-1 samples of the block before it. The M partial-result vectors are then summed through a chain of whole-block delay registers, one adder stage per group, in transposed form. The group with the highest tap indices enters at the far end of the chain.

Each product is formed by a column-wise (vertical and crosswise) partial-product multiplier. A register stage follows the multipliers, so the path through the multipliers is cut off from the path through the adder chain. Samples are unsigned. Results are exact sums, reduced modulo 2^OW. A valid flag goes with each input block and with each output block. Cycles on which the input is not valid leave the filter history untouched.

Top module: `fir_blk_top`

## Requirements
- R1: Each output sample equals y(n) = Σ h(t)·x(n−t) over t = 0..N−1, reduced modulo 2^OW, where x is the sequence of accepted samples and h is the coefficient parameter list.
- R2: Lane i of a block occupies bits [i·DW +: DW] of `in_data` and carries sample kL+i. Lane 0 is the oldest sample of the block. Output lane i occupies bits [i·OW +: OW] of `out_data` and carries y(kL+i).
- R3: `out_vld` is high exactly two clock edges after the edge that sampled `in_vld` high. Exactly one output block is produced per accepted input block.
- R4: On cycles with `in_vld` low, `in_data` is ignored and the history does not advance. The output sequence is therefore the same whatever the gaps between blocks and whatever data is present during them.
- R5: After a reset, every sample before the first accepted block counts as zero.
- R6: `out_data` keeps its value on every cycle on which `out_vld` is low.
- R7: With the default parameters (DW = 8, CW = 8, OW = 19, six taps), no output lane ever exceeds (2^DW − 1)·Σh, so full precision is kept.
- R8: While `rst_n` is low, `out_vld` is 0 and `out_data` is all zeros. Reset assertion is asynchronous. Release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Input block valid |
| in_data | input | L·DW | L unsigned samples, lane 0 oldest |
| out_vld | output | 1 | Output block valid |
| out_data | output | L·OW | L filtered samples, lane 0 oldest |

## Verification
The assertions check the following on every cycle: the two-edge gap between an accepted block and its result, that the output holds between valid blocks, the upper bound on every output lane, and the cleared state during reset. Numerical correctness cannot be seen by a property. That covers correct tap alignment across block boundaries, correct lane order, history that ignores idle cycles and garbage data, and the zero history after a mid-stream reset. These are shown only by the bench scenarios, where a sample-by-sample convolution model is compared with every output block.

// File: rtl/fir_blk_pkg.sv
package fir_blk_pkg;

  // Position inside the sample window (length 2L-1, index 0 = oldest carried
  // sample) that feeds output lane `lane` with tap offset `j` of a group.
  function automatic int unsigned win_idx(int unsigned lane, int unsigned j,
                                          int unsigned blk);
    return lane + blk - 1 - j;
  endfunction

endpackage

// File: rtl/fir_rst_sync.sv
module fir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign srst_n = sr_q[1];

endmodule

// File: rtl/fir_vc_mult.sv
// Unsigned multiplier built column by column: each result column collects the
// vertical and crosswise bit products of its weight plus the carry from the
// column below.
module fir_vc_mult #(
  parameter int unsigned AW = 8,
  parameter int unsigned BW = 8
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);

  localparam int unsigned PW = AW + BW;

  logic [PW-1:0] ax, bx;
  assign ax = PW'(a);
  assign bx = PW'(b);

  always_comb begin
    int unsigned col;
    int unsigned carry;
    carry = 0;
    p     = '0;
    for (int k = 0; k < PW - 1; k++) begin
      col = carry;
      for (int i = 0; i <= k; i++) begin
        col = col + {31'd0, ax[i] & bx[k-i]};
      end
      p[k]  = col[0];
      carry = col >> 1;
    end
    p[PW-1] = carry[0];
  end

endmodule

// File: rtl/fir_sub_prod.sv
// One tap group: L x L products of the sample window with the group's L
// coefficients, registered right after the multipliers.
module fir_sub_prod #(
  parameter int unsigned     DW    = 8,
  parameter int unsigned     CW    = 8,
  parameter int unsigned     L     = 2,
  parameter logic [L*CW-1:0] COEFV = '0
) (
  input  logic                     clk,
  input  logic                     srst_n,
  input  logic                     en,
  input  logic [(2*L-1)*DW-1:0]    win,
  output logic [L*L*(DW+CW)-1:0]   prod
);

  localparam int unsigned PW = DW + CW;

  logic [L*L-1:0][PW-1:0] mul_c;
  logic [L*L-1:0][PW-1:0] prod_d, prod_q;

  for (genvar gi = 0; gi < L; gi++) begin : g_lane
    for (genvar gj = 0; gj < L; gj++) begin : g_tap
      localparam int unsigned WI = fir_blk_pkg::win_idx(gi, gj, L);
      fir_vc_mult #(.AW(DW), .BW(CW)) u_mul (
        .a (win[WI*DW +: DW]),
        .b (COEFV[gj*CW +: CW]),
        .p (mul_c[gi*L+gj])
      );
    end
  end

  always_comb begin
    prod_d = prod_q;
    if (en) prod_d = mul_c;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) prod_q <= '0;
    else         prod_q <= prod_d;
  end

  assign prod = prod_q;

endmodule

// File: rtl/fir_blk_top.sv
module fir_blk_top #(
  parameter int unsigned DW   = 8,
  parameter int unsigned CW   = 8,
  parameter int unsigned L    = 2,
  parameter int unsigned M    = 3,
  parameter int unsigned COEF [L*M] = '{3, 250, 17, 128, 1, 77},
  parameter int unsigned OW   = DW + CW + $clog2(L*M)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [L*DW-1:0] in_data,
  output logic            out_vld,
  output logic [L*OW-1:0] out_data
);

  localparam int unsigned PW   = DW + CW;
  localparam int unsigned WINW = (2*L-1)*DW;

  function automatic logic [L*CW-1:0] grp_coefs(int unsigned m);
    logic [L*CW-1:0] v;
    v = '0;
    for (int unsigned j = 0; j < L; j++) v[j*CW +: CW] = CW'(COEF[m*L+j]);
    return v;
  endfunction

  logic srst_n;
  fir_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // carried samples of the previous block (its lanes 1..L-1)
  logic [(L-1)*DW-1:0] carry_d, carry_q;
  logic [WINW-1:0]     win;
  assign win = {in_data, carry_q};

  always_comb begin
    carry_d = carry_q;
    if (in_vld) carry_d = in_data[L*DW-1:DW];
  end

  logic [M-1:0][L*L*PW-1:0] prod;
  for (genvar gm = 0; gm < M; gm++) begin : g_grp
    fir_sub_prod #(.DW(DW), .CW(CW), .L(L), .COEFV(grp_coefs(gm))) u_grp (
      .clk    (clk),
      .srst_n (srst_n),
      .en     (in_vld),
      .win    (win),
      .prod   (prod[gm])
    );
  end

  // per-group lane sums of the registered products
  logic [M-1:0][L-1:0][OW-1:0] grp_sum;
  always_comb begin
    for (int m = 0; m < M; m++) begin
      for (int i = 0; i < L; i++) begin
        grp_sum[m][i] = '0;
        for (int j = 0; j < L; j++) begin
          grp_sum[m][i] = grp_sum[m][i] + OW'(prod[m][(i*L+j)*PW +: PW]);
        end
      end
    end
  end

  // transposed block delay chain, advanced only by valid product blocks
  logic                        pv_q;
  logic [M-1:1][L-1:0][OW-1:0] dl_d, dl_q;
  logic [L-1:0][OW-1:0]        y_d, y_q;
  logic                        ov_q;

  always_comb begin
    dl_d = dl_q;
    y_d  = y_q;
    if (pv_q) begin
      dl_d[M-1] = grp_sum[M-1];
      for (int m = 1; m < M - 1; m++) begin
        for (int i = 0; i < L; i++) dl_d[m][i] = grp_sum[m][i] + dl_q[m+1][i];
      end
      for (int i = 0; i < L; i++) y_d[i] = grp_sum[0][i] + dl_q[1][i];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      carry_q <= '0;
      pv_q    <= 1'b0;
      dl_q    <= '0;
      y_q     <= '0;
      ov_q    <= 1'b0;
    end else begin
      carry_q <= carry_d;
      pv_q    <= in_vld;
      dl_q    <= dl_d;
      y_q     <= y_d;
      ov_q    <= pv_q;
    end
  end

  assign out_vld  = ov_q;
  assign out_data = y_q;

endmodule

// File: rtl/fir_blk_chk.sv
module fir_blk_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned L  = 2,
  parameter int unsigned M  = 3,
  parameter int unsigned COEF [L*M] = '{3, 250, 17, 128, 1, 77},
  parameter int unsigned OW = 19
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic            out_vld,
  input logic [L*OW-1:0] out_data
);

  function automatic longint unsigned peak();
    longint unsigned s;
    s = 0;
    for (int unsigned t = 0; t < L*M; t++) s = s + 64'(COEF[t] & ((32'd1 << CW) - 1));
    return s * ((64'd1 << DW) - 1);
  endfunction

  localparam longint unsigned PEAK = peak();

  // R3: result block two edges after the accepting edge
  p_vld_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld, 2));

  // R6: output held between valid blocks
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_data));

  // R8: cleared state while reset is low
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r8: assert (out_vld == 1'b0 && out_data == '0);
    end
  end

  // R7: every lane stays within the full-precision bound
  if (OW < 64 && PEAK < (64'd1 << OW)) begin : g_bound
    localparam logic [OW-1:0] PEAK_O = OW'(PEAK);
    for (genvar gi = 0; gi < L; gi++) begin : g_lane
      p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_data[gi*OW +: OW] <= PEAK_O);
    end
  end

endmodule

bind fir_blk_top fir_blk_chk #(
  .DW(DW), .CW(CW), .L(L), .M(M), .COEF(COEF), .OW(OW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/fir_blk_top_tb_top.sv
module fir_blk_top_tb_top;

  localparam int DW = 8;
  localparam int L  = 2;
  localparam int N  = 6;
  localparam int OW = 19;

  int h [N] = '{3, 250, 17, 128, 1, 77};

  logic            clk = 1'b0;
  logic            rst_n = 1'b1;
  logic            in_vld = 1'b0;
  logic [L*DW-1:0] in_data = '0;
  logic            out_vld;
  logic [L*OW-1:0] out_data;

  fir_blk_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  always #5 clk = ~clk;

  int      total = 0;
  int      bad = 0;
  bit      done = 0;
  string   tag = "R1";
  longint  hist[$];
  longint  expq[$];
  bit      vp0 = 0, vp1 = 0;
  logic [L*OW-1:0] last_out = '0;

  function automatic longint conv(int n);
    longint s = 0;
    for (int t = 0; t < N; t++) if (n - t >= 0) s += longint'(h[t]) * hist[n-t];
    return s & ((64'd1 << OW) - 1);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the convolution model
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_vld == 1'b0, "R8 vld", longint'(out_vld), 0);
      chk(out_data == '0, "R8 data", longint'(out_data), 0);
      vp0 = 0; vp1 = 0; expq.delete(); last_out = '0;
    end else if (!done) begin
      bit ev;
      ev = vp1; vp1 = vp0; vp0 = in_vld;
      chk(out_vld == ev, "R3", longint'(out_vld), longint'(ev));
      if (ev && out_vld) begin
        for (int i = 0; i < L; i++) begin
          longint e;
          e = (expq.size() > 0) ? expq.pop_front() : -1;
          chk(longint'(out_data[i*OW +: OW]) == e, {tag, " lane"},
              longint'(out_data[i*OW +: OW]), e);
        end
      end else if (!out_vld) begin
        chk(out_data == last_out, "R6", longint'(out_data), longint'(last_out));
      end
      last_out = out_data;
    end
  end

  task automatic send(logic [L*DW-1:0] d);
    @(posedge clk); #1;
    in_vld = 1'b1; in_data = d;
    for (int i = 0; i < L; i++) hist.push_back(longint'(d[i*DW +: DW]));
    for (int i = 0; i < L; i++) expq.push_back(conv(hist.size() - L + i));
  endtask

  task automatic idle(int n, bit junk);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      in_vld = 1'b0;
      in_data = junk ? L*DW'($urandom) : '0;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    in_vld = 1'b0;
    rst_n = 1'b0;
    hist.delete();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: impulse in lane 0, then lane 1 -> taps appear in lane order
    tag = "R2";
    send(16'h0001);
    for (int b = 0; b < 4; b++) send(16'h0000);
    send(16'h0100);
    for (int b = 0; b < 4; b++) send(16'h0000);
    idle(4, 0);

    // R7: full-scale input for many blocks
    tag = "R7";
    for (int b = 0; b < 6; b++) send(16'hFFFF);
    idle(4, 0);

    // R1: dense random stream
    tag = "R1";
    for (int b = 0; b < 150; b++) send(L*DW'($urandom));
    idle(3, 0);

    // R4: random stream with random gaps carrying junk data
    tag = "R4";
    for (int b = 0; b < 150; b++) begin
      send(L*DW'($urandom));
      idle(int'($urandom_range(0, 3)), 1);
    end
    idle(3, 1);

    // R5: reset with blocks in flight, then history must restart at zero
    send(16'hFFFF); send(16'h8080);
    do_reset();
    tag = "R5";
    send(16'h0302);
    send(16'h0504);
    for (int b = 0; b < 4; b++) send(L*DW'($urandom));
    idle(5, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule